// File: doc/BRIEF.md
# Snapshot Counter with Request Handshake

This block keeps a free-running 64-bit up-counter that advances once for every cycle in which the tick-enable input is high. Software cannot see the live count. It reaches the counter through three 32-bit registers on a simple word bus: one control register and two read-only data words.

Software controls the counter with two request bits in the control register. One request zeroes the counter. The other copies the whole 64-bit count into a snapshot. Each request bit reads back as 1 until its operation has taken effect, so software polls the bit until it drops. Each operation completes after a programmable number of ticks, which models the crossing into the counter's clock domain.

After a snapshot completes, the low and high data words both come from the same stored copy. The two words therefore always form one coherent value, however far the live counter has moved since. The control register also holds a two-bit clock-source field. Any write that carries the clear request forces that field back to the oscillator code.

Top module: `snapshot_counter`

## Requirements
- R1: After reset, the control register, the low word and the high word all read as zero.
- R2: The counter advances by one only in cycles where tickEn is high. Clock cycles without tickEn leave it unchanged.
- R3: Writing 1 to control bit 0 (clear request) makes bit 0 read 1. The bit stays 1 through idle clock cycles and through the first SYNC_TICKS-1 ticks. At the SYNC_TICKS-th tick the counter becomes zero and the bit reads 0 again.
- R4: Writing 1 to control bit 1 (latch request) makes bit 1 read 1. At the SYNC_TICKS-th tick after the write, the snapshot takes the count value present before that tick's increment, and bit 1 reads 0 again.
- R5: The low word (offset 0xa4) returns snapshot bits 31:0 and the high word (offset 0xa8) returns bits 63:32. Neither word changes until the next latch request completes, however many ticks occur in between.
- R6: When a clear and a latch complete on the same tick (for example, when both were requested in one write), the clear comes first: the snapshot captures zero and the counter restarts from zero.
- R7: A request written while the same request is still pending is ignored. The pending operation completes at its original tick.
- R8: Control bits 3:2 hold the clock-source code, and 2'b00 is the oscillator. A control write without bit 0 stores bits 3:2. A control write with bit 0 set stores 2'b00 whatever bits 3:2 carry.
- R9: Writes to the data offsets have no effect. Reads of any offset other than 0xa0, 0xa4 and 0xa8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter tick qualifier from the oscillator |
| busAddr | input | 8 | Byte offset of the register being accessed |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |

## Verification
The counter is driven with tick bursts that have no gaps, one idle cycle or three idle cycles between ticks. This separates counting on tickEn from counting on clk. Pending bits are polled across idle cycles and after the SYNC_TICKS-1-th and SYNC_TICKS-th ticks, which pins the completion tick exactly. The bench also issues a clear alone, a latch alone, both in one write, and a repeated latch while one is still pending. Together these separate clear-before-latch ordering, ignored re-requests and the pre-increment capture value. Re-reading the snapshot after many further ticks, and after writes to the data offsets, shows that the words come from a held copy and not the live count.

// File: rtl/snapshot_counter_pkg.sv
package snapshot_counter_pkg;

  // Strobes from the request control to the counter datapath
  typedef struct packed {
    logic doClear;
    logic doLatch;
  } cntStrobe_t;

  // Control register bit positions (software visible)
  localparam int CLR_BIT   = 0;
  localparam int LATCH_BIT = 1;
  localparam int SRC_LSB   = 2;
  localparam int SRC_W     = 2;
  localparam int NUM_REQ   = 2;

  localparam logic [SRC_W-1:0] SRC_OSC = 2'b00;

endpackage

// File: rtl/snapshot_counter_ctrl.sv
module snapshot_counter_ctrl
  import snapshot_counter_pkg::*;
#(
  parameter int SYNC_TICKS = 3,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'ha0,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 8'ha4,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 8'ha8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  snapValue,
  output cntStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdData
);

  localparam int WAIT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(SYNC_TICKS - 1);

  logic               ctrlWr;
  logic [NUM_REQ-1:0] pendVec;
  logic [NUM_REQ-1:0] doneVec;
  logic [SRC_W-1:0]   srcSel;
  logic               unusedWrBits;

  assign ctrlWr       = busWrEn && (busAddr == CTRL_OFS);
  assign unusedWrBits = ^busWrData[DATA_W-1:SRC_LSB+SRC_W];

  // One request channel per control bit: pending flag plus tick wait counter
  for (genvar ch = 0; ch < NUM_REQ; ch++) begin : g_req
    logic              pendReg;
    logic [WAIT_W-1:0] waitCnt;
    logic              reqHit;

    assign reqHit = ctrlWr && busWrData[ch];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendReg <= 1'b0;
        waitCnt <= '0;
      end else if (!pendReg) begin
        if (reqHit) begin
          pendReg <= 1'b1;
          waitCnt <= '0;
        end
      end else if (tickEn) begin
        if (waitCnt == LAST_WAIT) begin
          pendReg <= 1'b0;
          waitCnt <= '0;
        end else begin
          waitCnt <= waitCnt + WAIT_W'(1);
        end
      end
    end

    assign pendVec[ch] = pendReg;
    assign doneVec[ch] = pendReg && tickEn && (waitCnt == LAST_WAIT);
  end

  assign strobe.doClear = doneVec[CLR_BIT];
  assign strobe.doLatch = doneVec[LATCH_BIT];

  // Clock-source field: a clear request forces the oscillator code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel <= SRC_OSC;
    end else if (ctrlWr) begin
      if (busWrData[CLR_BIT]) begin
        srcSel <= SRC_OSC;
      end else begin
        srcSel <= busWrData[SRC_LSB +: SRC_W];
      end
    end
  end

  // Read decode
  always_comb begin
    busRdData = '0;
    case (busAddr)
      CTRL_OFS: busRdData = {{(DATA_W-SRC_W-NUM_REQ){1'b0}}, srcSel, pendVec};
      LOW_OFS:  busRdData = snapValue[DATA_W-1:0];
      HIGH_OFS: busRdData = snapValue[CNT_W-1:DATA_W];
      default:  busRdData = '0;
    endcase
  end

  AST_CLR_WAITS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[CLR_BIT] && !tickEn) |=> pendVec[CLR_BIT]); // R3
  AST_LATCH_WAITS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec[LATCH_BIT] && !tickEn) |=> pendVec[LATCH_BIT]); // R4
  AST_LATCH_REQ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWrData[LATCH_BIT]) |=> pendVec[LATCH_BIT]); // R4
  AST_CLEAR_FORCES_OSC: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWrData[CLR_BIT]) |=> (srcSel == SRC_OSC)); // R8

endmodule

// File: rtl/snapshot_counter_dp.sv
module snapshot_counter_dp
  import snapshot_counter_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  cntStrobe_t       strobe,
  output logic [CNT_W-1:0] snapValue
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] snapReg;

  // Live counter: clear wins over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.doClear) begin
      count <= '0;
    end else if (tickEn) begin
      count <= count + CNT_W'(1);
    end
  end

  // Snapshot: a simultaneous clear is applied first, so zero is captured
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReg <= '0;
    end else if (strobe.doLatch) begin
      snapReg <= strobe.doClear ? '0 : count;
    end
  end

  assign snapValue = snapReg;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.doClear) |=> (count == $past(count) + CNT_W'(1))); // R2
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn) |=> $stable(count)); // R2
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doClear |=> (count == '0)); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doLatch) |=> $stable(snapReg)); // R5
  AST_ZERO_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doClear && strobe.doLatch) |=> (snapReg == '0)); // R6

endmodule

// File: rtl/snapshot_counter.sv
module snapshot_counter
  import snapshot_counter_pkg::*;
#(
  parameter int SYNC_TICKS = 3,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  localparam int CNT_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  cntStrobe_t       strobe;
  logic [CNT_W-1:0] snapValue;

  snapshot_counter_ctrl #(
    .SYNC_TICKS(SYNC_TICKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .snapValue(snapValue),
    .strobe   (strobe),
    .busRdData(busRdData)
  );

  snapshot_counter_dp #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobe   (strobe),
    .snapValue(snapValue)
  );

endmodule

// File: tb/snapshot_counter_tb.sv
module snapshot_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 3;
  localparam logic [7:0] A_CTRL = 8'ha0;
  localparam logic [7:0] A_LOW  = 8'ha4;
  localparam logic [7:0] A_HIGH = 8'ha8;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rdReq = 1'b0;

  int errors = 0;
  int checks = 0;
  expItem_t scoreQ[$];

  // Reference model state, updated from the requirements
  logic [63:0] mCount = '0;
  logic [63:0] mSnap  = '0;
  logic [1:0]  mSrc   = '0;
  int clrLeft = 0;
  int latLeft = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snapshot_counter #(.SYNC_TICKS(SYNC)) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData)
  );

  function automatic logic [31:0] ctrlExp();
    return {28'b0, mSrc, latLeft != 0, clrLeft != 0};
  endfunction

  // Monitor: pops expected items and compares them away from the clock edge
  always @(negedge clk) begin
    if (rdReq) begin
      expItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (busRdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdData, it.exp);
      end
    end
  end

  task automatic busRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    scoreQ.push_back(it);
    busAddr = a;
    rdReq = 1'b1;
    @(posedge clk); #1;
    rdReq = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
    if (a == A_CTRL) begin
      mSrc = d[0] ? 2'b00 : d[3:2];
      if (d[0] && clrLeft == 0) clrLeft = SYNC;
      if (d[1] && latLeft == 0) latLeft = SYNC;
    end
  endtask

  task automatic runTicks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      logic doC, doL;
      tickEn = 1'b1;
      @(posedge clk); #1;
      tickEn = 1'b0;
      doC = (clrLeft == 1);
      doL = (latLeft == 1);
      if (clrLeft != 0) clrLeft--;
      if (latLeft != 0) latLeft--;
      if (doL) mSnap = doC ? 64'd0 : mCount;
      if (doC) mCount = '0; else mCount = mCount + 64'd1;
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  task automatic readSnap(input string tag);
    busRead(A_LOW,  mSnap[31:0],  tag);
    busRead(A_HIGH, mSnap[63:32], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 reset values
    busRead(A_CTRL, 32'h0, "R1 ctrl");
    busRead(A_LOW,  32'h0, "R1 low");
    busRead(A_HIGH, 32'h0, "R1 high");

    // R2 tick patterns with gaps
    runTicks(2, 0);
    runTicks(2, 1);
    runTicks(1, 3);

    // R4 latch handshake, polled across idle cycles and partial ticks
    busWrite(A_CTRL, 32'h2);
    busRead(A_CTRL, ctrlExp(), "R4 pending set");
    repeat (4) begin @(posedge clk); #1; end
    busRead(A_CTRL, ctrlExp(), "R4 no completion without ticks");
    runTicks(SYNC - 1, 1);
    busRead(A_CTRL, ctrlExp(), "R4 pending before last tick");
    runTicks(1, 0);
    busRead(A_CTRL, ctrlExp(), "R4 pending dropped");
    readSnap("R4 R2 snapshot value");

    // R5 snapshot held while counter runs
    runTicks(10, 0);
    readSnap("R5 snapshot stable");

    // R3 + R8 clear with source field forced to oscillator
    busWrite(A_CTRL, 32'hd);
    busRead(A_CTRL, ctrlExp(), "R3 R8 clear pending, src oscillator");
    runTicks(SYNC - 1, 2);
    busRead(A_CTRL, ctrlExp(), "R3 pending before last tick");
    runTicks(1, 0);
    busRead(A_CTRL, ctrlExp(), "R3 pending dropped");
    runTicks(4, 0);
    busWrite(A_CTRL, 32'h2);
    runTicks(SYNC, 0);
    readSnap("R3 count restarted from zero");

    // R8 source field stored without clear
    busWrite(A_CTRL, 32'h8);
    busRead(A_CTRL, ctrlExp(), "R8 src stored");

    // R6 both requests in one write
    runTicks(5, 1);
    busWrite(A_CTRL, 32'h3);
    runTicks(SYNC, 0);
    busRead(A_CTRL, ctrlExp(), "R6 both done");
    readSnap("R6 snapshot zero");
    runTicks(4, 0);
    busWrite(A_CTRL, 32'h2);
    runTicks(SYNC, 1);
    readSnap("R6 counter restarted");

    // R7 re-request while pending is ignored
    runTicks(3, 0);
    busWrite(A_CTRL, 32'h2);
    runTicks(1, 0);
    busWrite(A_CTRL, 32'h2);
    runTicks(SYNC - 1, 0);
    busRead(A_CTRL, ctrlExp(), "R7 completes at original tick");
    readSnap("R7 snapshot from first request");

    // R9 data offsets read-only, unmapped offsets read zero
    busWrite(A_LOW, 32'hffffffff);
    busWrite(A_HIGH, 32'hffffffff);
    readSnap("R9 data write ignored");
    busRead(8'h00, 32'h0, "R9 unmapped 0x00");
    busRead(8'hac, 32'h0, "R9 unmapped 0xac");

    @(posedge clk); #1;
    if (scoreQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", scoreQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule